// File: doc/BRIEF.md
# Complex Digital Quadrature Modulator

This block moves a complex baseband stream up or down in frequency by a fixed fraction of its own sample rate. It sits in a dual-converter transmit path, after the interpolation filters and before the converter cores. Each accepted input sample is a signed I and Q pair qualified by a valid strobe. For each one, the block produces one rotated I/Q pair, registered one clock later. The output sample rate is the input sample rate.

A two-bit mode input selects one of three settings: pass-through, a shift by half the sample rate, or a shift by a quarter of the sample rate. A direction input picks the rotation sign. Low selects the negative exponent e^-jw, and high selects e^+jw, which places the wanted signal in the opposite sideband. The sample rate into the block can be the full converter rate or half of it, as in the highest interpolation setting. That rate shows only in how often the upstream logic raises the valid strobe. The phase follows accepted samples, not clock cycles.

Only quarter and half turns are needed, so every complex multiply reduces to swaps and negations of I and Q. No oscillator or table is needed. A four-state phase machine (PH_0, PH_1, PH_2, PH_3) steps PH_0→PH_1→PH_2→PH_3→PH_0 on each accepted sample and holds its state on idle cycles.

Top module: `qm_quad_mod`

## Requirements
- R1: Reset clears out_valid, out_i and out_q to zero and returns the phase machine to PH_0, so the first sample after reset uses phase index 0.
- R2: Each cycle with in_valid high yields exactly one output: out_valid is high on the clock after a cycle with in_valid high, and low on the clock after a cycle with in_valid low.
- R3: With mode_sel 2'b00 (off) or 2'b11 (spare, also off), out_i and out_q equal the accepted in_i and in_q, with the same one-clock latency as the active modes.
- R4: With mode_sel 2'b01 (half rate), samples with an even phase index pass unchanged and samples with an odd index have both I and Q negated, whatever dir_pos is.
- R5: With mode_sel 2'b10 (quarter rate) and dir_pos 0, phase indices 0, 1, 2 and 3 give (I,Q), (Q,-I), (-I,-Q) and (-Q,I) respectively.
- R6: With mode_sel 2'b10 and dir_pos 1, phase indices 0, 1, 2 and 3 give (I,Q), (-Q,I), (-I,-Q) and (Q,-I) respectively.
- R7: The phase index advances only on cycles with in_valid high. On idle cycles the phase, out_i and out_q hold their values.
- R8: Negating the most negative code (-2^(DW-1)) gives the most positive code (2^(DW-1)-1) rather than wrapping.
- R9: The phase index advances on every accepted sample in every mode, off included. mode_sel and dir_pos are applied sample by sample at the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | DW | Signed in-phase input |
| in_q | input | DW | Signed quadrature input |
| mode_sel | input | 2 | 00 off, 01 half rate, 10 quarter rate, 11 off |
| dir_pos | input | 1 | 0 selects e^-jw, 1 selects e^+jw |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | DW | Signed in-phase output |
| out_q | output | DW | Signed quadrature output |

## Verification
The hardest situation to reach from the ports is one where the result depends on a phase index that the ports never show. This covers the index after idle gaps, after samples taken in off mode, and just after a mid-stream reset. The stimulus counts every accepted sample from reset and interleaves idle cycles, off-mode samples and a reset between quarter-rate samples. A wrong phase then appears as a rotated pair that is visibly wrong. The saturating negation needs the most negative code to reach a negating phase. The vectors therefore place that code at an odd half-rate index and at quarter-rate indices 2 and 3.

// File: rtl/qm_pkg.sv
package qm_pkg;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_HALF    = 2'b01,
        MODE_QUARTER = 2'b10,
        MODE_SPARE   = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        PH_0 = 2'd0,
        PH_1 = 2'd1,
        PH_2 = 2'd2,
        PH_3 = 2'd3
    } phase_e;

    // Rotation applied to a sample: P90 multiplies by +j, M90 by -j.
    typedef enum logic [1:0] {
        ROT_0   = 2'd0,
        ROT_P90 = 2'd1,
        ROT_180 = 2'd2,
        ROT_M90 = 2'd3
    } rot_e;

endpackage

// File: rtl/qm_phase_seq.sv
module qm_phase_seq
    import qm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   adv,
    output phase_e phase
);

    phase_e state_q;
    phase_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (adv) begin
            unique case (state_q)
                PH_0: state_d = PH_1;
                PH_1: state_d = PH_2;
                PH_2: state_d = PH_3;
                PH_3: state_d = PH_0;
            endcase
        end
    end

    assign phase = state_q;

    // R7
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state_q));

    // R9
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && state_q == PH_3) |=> state_q == PH_0);

    // R9
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && state_q == PH_0) |=> state_q == PH_1);

endmodule

// File: rtl/qm_rot_select.sv
module qm_rot_select
    import qm_pkg::*;
(
    input  logic [1:0] mode_sel,
    input  logic       dir_pos,
    input  phase_e     phase,
    output rot_e       rot
);

    mode_e mode;
    assign mode = mode_e'(mode_sel);

    always_comb begin
        rot = ROT_0;
        unique case (mode)
            MODE_OFF, MODE_SPARE: rot = ROT_0;
            MODE_HALF: begin
                rot = (phase == PH_1 || phase == PH_3) ? ROT_180 : ROT_0;
            end
            MODE_QUARTER: begin
                unique case (phase)
                    PH_0: rot = ROT_0;
                    PH_1: rot = dir_pos ? ROT_P90 : ROT_M90;
                    PH_2: rot = ROT_180;
                    PH_3: rot = dir_pos ? ROT_M90 : ROT_P90;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/qm_rotator.sv
module qm_rotator
    import qm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] a_i,
    input  logic signed [DW-1:0] a_q,
    input  rot_e                 rot,
    output logic signed [DW-1:0] y_i,
    output logic signed [DW-1:0] y_q
);

    localparam logic signed [DW-1:0] MIN_CODE = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] MAX_CODE = {1'b0, {(DW-1){1'b1}}};

    function automatic logic signed [DW-1:0] neg_sat(input logic signed [DW-1:0] x);
        return (x == MIN_CODE) ? MAX_CODE : -x;
    endfunction

    logic signed [DW-1:0] n_i;
    logic signed [DW-1:0] n_q;

    assign n_i = neg_sat(a_i);
    assign n_q = neg_sat(a_q);

    always_comb begin
        y_i = a_i;
        y_q = a_q;
        unique case (rot)
            ROT_0:   begin y_i = a_i; y_q = a_q; end
            ROT_P90: begin y_i = n_q; y_q = a_i; end
            ROT_180: begin y_i = n_i; y_q = n_q; end
            ROT_M90: begin y_i = a_q; y_q = n_i; end
        endcase
    end

endmodule

// File: rtl/qm_quad_mod.sv
module qm_quad_mod
    import qm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic [1:0]           mode_sel,
    input  logic                 dir_pos,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q
);

    localparam logic signed [DW-1:0] MIN_CODE = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] MAX_CODE = {1'b0, {(DW-1){1'b1}}};

    phase_e               phase;
    rot_e                 rot;
    logic signed [DW-1:0] rot_i;
    logic signed [DW-1:0] rot_q;

    qm_phase_seq u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .phase (phase)
    );

    qm_rot_select u_sel (
        .mode_sel (mode_sel),
        .dir_pos  (dir_pos),
        .phase    (phase),
        .rot      (rot)
    );

    qm_rotator #(.DW(DW)) u_rot (
        .a_i (in_i),
        .a_q (in_q),
        .rot (rot),
        .y_i (rot_i),
        .y_q (rot_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_i <= rot_i;
                out_q <= rot_q;
            end
        end
    end

    // R2
    valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode_sel == 2'b00 || mode_sel == 2'b11))
        |=> (out_i == $past(in_i) && out_q == $past(in_q)));

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_i) && $stable(out_q)));

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_i == MIN_CODE && in_q == MIN_CODE)
        |=> ((out_i == MIN_CODE || out_i == MAX_CODE) &&
             (out_q == MIN_CODE || out_q == MAX_CODE)));

endmodule

// File: tb/tb_qm_quad_mod.sv
`timescale 1ns/1ps
module tb_qm_quad_mod;

    localparam int DW = 16;

    typedef struct packed {
        logic [1:0]           mode;
        logic                 dir;
        logic signed [DW-1:0] si;
        logic signed [DW-1:0] sq;
        logic signed [DW-1:0] ei;
        logic signed [DW-1:0] eq;
    } vec_t;

    // One entry per accepted sample; phase index is the entry number mod 4.
    localparam vec_t TBL [16] = '{
        '{2'b00, 1'b0,  16'sd100,   -16'sd50,   16'sd100,   -16'sd50},
        '{2'b11, 1'b1,  16'sd7,     16'sd8,     16'sd7,     16'sd8},
        '{2'b01, 1'b0,  16'sd10,    16'sd20,    16'sd10,    16'sd20},
        '{2'b01, 1'b1,  16'sd10,    16'sd20,    -16'sd10,   -16'sd20},
        '{2'b10, 1'b0,  16'sd300,   -16'sd400,  16'sd300,   -16'sd400},
        '{2'b10, 1'b0,  16'sd300,   -16'sd400,  -16'sd400,  -16'sd300},
        '{2'b10, 1'b0,  16'sd300,   -16'sd400,  -16'sd300,  16'sd400},
        '{2'b10, 1'b0,  16'sd300,   -16'sd400,  16'sd400,   16'sd300},
        '{2'b10, 1'b1,  16'sd5,     16'sd9,     16'sd5,     16'sd9},
        '{2'b10, 1'b1,  16'sd5,     16'sd9,     -16'sd9,    16'sd5},
        '{2'b10, 1'b1,  16'sd5,     16'sd9,     -16'sd5,    -16'sd9},
        '{2'b10, 1'b1,  16'sd5,     16'sd9,     16'sd9,     -16'sd5},
        '{2'b01, 1'b0,  -16'sd32768, 16'sd1,    -16'sd32768, 16'sd1},
        '{2'b01, 1'b0,  -16'sd32768, -16'sd32768, 16'sd32767, 16'sd32767},
        '{2'b10, 1'b0,  -16'sd32768, 16'sd32767, 16'sd32767, -16'sd32767},
        '{2'b10, 1'b1,  -16'sd32768, 16'sd3,    16'sd3,     16'sd32767}
    };

    localparam string TAGS [16] = '{
        "R3", "R3", "R4", "R4", "R5", "R5", "R5", "R5",
        "R6", "R6", "R6", "R6", "R4", "R8", "R8", "R8"
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_i = '0;
    logic signed [DW-1:0] in_q = '0;
    logic [1:0]           mode_sel = 2'b00;
    logic                 dir_pos = 1'b0;
    logic                 out_valid;
    logic signed [DW-1:0] out_i;
    logic signed [DW-1:0] out_q;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    qm_quad_mod #(.DW(DW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_i      (in_i),
        .in_q      (in_q),
        .mode_sel  (mode_sel),
        .dir_pos   (dir_pos),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one sample, then check its result one clock later.
    task automatic send(input logic [1:0] m, input logic d,
                        input int si, input int sq,
                        input int ei, input int eq, input string tag);
        @(negedge clk);
        mode_sel = m; dir_pos = d;
        in_i = DW'(si); in_q = DW'(sq);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " valid"}, int'(out_valid), 1);
        chk({tag, " i"}, int'(out_i), ei);
        chk({tag, " q"}, int'(out_q), eq);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", int'(out_valid), 0);
        chk("R1 i", int'(out_i), 0);
        chk("R1 q", int'(out_q), 0);
        rst_n = 1'b1;

        for (int k = 0; k < 16; k++) begin
            send(TBL[k].mode, TBL[k].dir, int'(TBL[k].si), int'(TBL[k].sq),
                 int'(TBL[k].ei), int'(TBL[k].eq), TAGS[k]);
        end

        // R7: idle cycles keep outputs and phase (index is 0 here)
        repeat (5) @(negedge clk);
        chk("R7 idle valid", int'(out_valid), 0);
        chk("R7 hold i", int'(out_i), 3);
        chk("R7 hold q", int'(out_q), 32767);
        send(2'b10, 1'b0, 1, 2, 1, 2, "R7");
        send(2'b10, 1'b0, 1, 2, 2, -1, "R7");

        // R9: off-mode samples still advance the index (2 -> 3 -> 0)
        send(2'b00, 1'b0, 11, 12, 11, 12, "R9");
        send(2'b00, 1'b1, 13, 14, 13, 14, "R9");
        send(2'b10, 1'b0, 6, 7, 6, 7, "R9");

        // R2: back-to-back samples, half rate, indices 1, 2, 3
        @(negedge clk);
        mode_sel = 2'b01; dir_pos = 1'b1; in_i = 16'sd4; in_q = 16'sd4;
        in_valid = 1'b1;
        @(negedge clk);
        chk("R2 b2b valid", int'(out_valid), 1);
        chk("R2 b2b i", int'(out_i), -4);
        @(negedge clk);
        chk("R2 b2b valid", int'(out_valid), 1);
        chk("R2 b2b i", int'(out_i), 4);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 b2b valid", int'(out_valid), 1);
        chk("R2 b2b q", int'(out_q), -4);
        @(negedge clk);
        chk("R2 idle valid", int'(out_valid), 0);

        // R1: reset mid-stream returns the index to 0
        send(2'b10, 1'b0, 1, 2, 1, 2, "R5");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid valid", int'(out_valid), 0);
        chk("R1 mid i", int'(out_i), 0);
        chk("R1 mid q", int'(out_q), 0);
        rst_n = 1'b1;
        send(2'b10, 1'b0, 3, 5, 3, 5, "R1");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule